// File: doc/BRIEF.md
# Multi-Phase Volume Envelope Generator

This block shapes the loudness of one voice. It walks through an optional pre-attack delay, a linear attack up to full scale, a hold at full scale, a decay in the log domain down to a sustain level, and a release down to silence. Every step is paced by a single-cycle sample tick. The 16-bit envelope level drives a volume multiplier further down the datapath. A 3-bit phase code is brought out next to it.

Software sets the envelope through three write selects. One loads the 16-bit state variable that sets the pre-attack delay. One carries the hold and attack codes. One carries the sustain level, the decay code and a freeze bit. Bit 15 of the second and third words is a phase command. A 0 in either word starts a new note, and a 1 in the third word starts the release. While the freeze bit is set, the engine ignores ticks and the envelope stands still.

Top module: `venv_gen`

## Requirements
- R1: After reset, `env_level` is 0 and `env_phase` is IDLE. The phase codes are IDLE=0, DELAY=1, ATTACK=2, HOLD=3, DECAY=4, SUSTAIN=5 and RELEASE=6.
- R2: A write with `wr_sel`=1 and `wr_data[15]`=0, or with `wr_sel`=2 and `wr_data[15]`=0, moves the phase to DELAY and sets the level to 0 at that clock edge. A write with `wr_sel`=1 and `wr_data[15]`=1 stores the codes and leaves the phase unchanged.
- R3: The state variable S is loaded by a write with `wr_sel`=0. In DELAY the level is 0. If S = 0x8000-n with n of at least 1, the n-th tick moves the phase to ATTACK, and S counts up once per tick until it reaches 0x8000. If S is 0x7FFF or more, the first tick moves the phase to ATTACK.
- R4: The attack code A is `wr_data[6:0]` of the `wr_sel`=1 word. For A above 0, each tick in ATTACK adds (A+1)·2^(A>>4) to the level. When the sum would reach 0xFFFF or more, the level is set to 0xFFFF and the phase moves to HOLD.
- R5: With attack code 0 the level stays at 0 and the phase stays in ATTACK for any number of ticks.
- R6: The hold code H is `wr_data[14:8]` of the `wr_sel`=1 word. HOLD lasts exactly 128-H ticks at level 0xFFFF, and the phase then moves to DECAY.
- R7: The sustain code U is `wr_data[14:8]` of the `wr_sel`=2 word, and its steps are roughly 0.75 dB each. The sustain target is 0 when U=0. Otherwise, with k=127-U, the target is (0xFFFF - 4096·(k mod 8)) >> (k div 8). So U=127 gives 0xFFFF, U=120 gives 36863, U=119 gives 32767 and U=1 gives 1.
- R8: The decay code D is `wr_data[6:0]` of the `wr_sel`=2 word. Each tick in DECAY subtracts (L >> (8-(D>>4))) + (D mod 16) + 1 from the current level L. If the result would be at or below the sustain target, the level is set to the target and the phase moves to SUSTAIN. SUSTAIN then holds both phase and level across ticks.
- R9: A write with `wr_sel`=2 and `wr_data[15]`=1 moves any phase to RELEASE and keeps the level. Each tick in RELEASE subtracts the R8 step. If the level is at or below the step, the level is set to 0 and the phase moves to IDLE.
- R10: While the freeze bit (`wr_data[7]` of the last `wr_sel`=2 word) is 1, ticks change neither the level, the phase, nor the delay or hold progress. Writes still take effect.
- R11: A write with `wr_sel`=3 has no effect. In a cycle with any write, a coincident tick is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample-period advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 state, 1 hold/attack, 2 sustain/decay, 3 none |
| wr_data | input | 16 | Write data |
| env_level | output | 16 | Envelope level for the volume multiplier |
| env_phase | output | 3 | Current phase code |

## Verification
The freeze bit is hard to reach mid-phase. It lives in the same word whose bit 15 always issues a start or a release, so the engine cannot be frozen partway through a decay or a hold. The bench therefore sets the freeze bit together with a release from a sustained level, and together with a start that has a long pending delay. It then checks that the level and the remaining delay count survive a run of ticks. A delay reload that lands in the same cycle as a tick is another rare coincidence. The bench drives both strobes in one cycle and then counts the ticks to ATTACK to show that the reloaded value alone sets the remaining delay.

// File: rtl/venv_pkg.sv
package venv_pkg;
  localparam int unsigned LVL_W   = 16;
  localparam int unsigned CODE_W  = 7;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned RATE_W  = 3;   // upper code bits: exponent of the rate
  localparam int unsigned MANT_W  = 4;   // lower code bits: linear part of the rate
  localparam int unsigned FRAC_W  = 3;   // eighths of a 6 dB octave in the sustain code
  localparam int unsigned CMD_BIT = 15;
  localparam int unsigned FRZ_BIT = 7;
  localparam int unsigned HI_LSB  = 8;

  localparam logic [SEL_W-1:0] SEL_STATE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_AH    = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DS    = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DELAY   = 3'd1,
    PH_ATTACK  = 3'd2,
    PH_HOLD    = 3'd3,
    PH_DECAY   = 3'd4,
    PH_SUSTAIN = 3'd5,
    PH_RELEASE = 3'd6
  } venv_phase_e;

  // Linear attack increment: (code+1) scaled by 2^(code>>4); code 0 never advances.
  function automatic logic [LVL_W-1:0] f_attack_step(input logic [CODE_W-1:0] a);
    logic [LVL_W-1:0] base;
    base = LVL_W'(a) + LVL_W'(1);
    if (a == '0) return '0;
    return base << a[CODE_W-1:CODE_W-RATE_W];
  endfunction

  // Proportional (log-domain) decrement: a fraction of the level plus a floor.
  function automatic logic [LVL_W-1:0] f_decay_step(input logic [LVL_W-1:0] lv,
                                                   input logic [CODE_W-1:0] d);
    logic [3:0] sh;
    sh = 4'd8 - {1'b0, d[CODE_W-1:CODE_W-RATE_W]};
    return (lv >> sh) + LVL_W'(d[MANT_W-1:0]) + LVL_W'(1);
  endfunction

  // Sustain target: octave shift from the upper bits of the attenuation,
  // piecewise-linear mantissa from the lower three bits.
  function automatic logic [LVL_W-1:0] f_sustain_target(input logic [CODE_W-1:0] s);
    logic [CODE_W-1:0] k;
    logic [LVL_W-1:0]  mant;
    if (s == '0) return '0;
    k    = ~s;
    mant = {LVL_W{1'b1}} - (LVL_W'(k[FRAC_W-1:0]) << (LVL_W - 4));
    return mant >> k[CODE_W-1:FRAC_W];
  endfunction
endpackage

// File: rtl/venv_regs.sv
module venv_regs
  import venv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [LVL_W-1:0]  wr_data,
  output logic [CODE_W-1:0] atk_code,
  output logic [CODE_W-1:0] hold_code,
  output logic [CODE_W-1:0] sus_code,
  output logic [CODE_W-1:0] dec_code,
  output logic              frozen,
  output logic              start_evt,
  output logic              release_evt,
  output logic              cnt_load
);
  logic sel_ah, sel_ds;

  assign sel_ah      = wr_en && (wr_sel == SEL_AH);
  assign sel_ds      = wr_en && (wr_sel == SEL_DS);
  assign start_evt   = (sel_ah || sel_ds) && !wr_data[CMD_BIT];
  assign release_evt = sel_ds && wr_data[CMD_BIT];
  assign cnt_load    = wr_en && (wr_sel == SEL_STATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atk_code  <= '0;
      hold_code <= '0;
      sus_code  <= '0;
      dec_code  <= '0;
      frozen    <= 1'b0;
    end else if (sel_ah) begin
      hold_code <= wr_data[HI_LSB +: CODE_W];
      atk_code  <= wr_data[CODE_W-1:0];
    end else if (sel_ds) begin
      sus_code  <= wr_data[HI_LSB +: CODE_W];
      frozen    <= wr_data[FRZ_BIT];
      dec_code  <= wr_data[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/venv_timer.sv
module venv_timer
  import venv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_load,
  input  logic [LVL_W-1:0]  cnt_wdata,
  input  logic              delay_adv,
  input  logic              hold_load,
  input  logic [CODE_W-1:0] hold_code,
  input  logic              hold_adv,
  output logic              delay_done,
  output logic              hold_done
);
  localparam logic [LVL_W-1:0] ORIGIN = LVL_W'(1) << (LVL_W - 1);
  localparam logic [LVL_W-1:0] LAST   = ORIGIN - LVL_W'(1);

  logic [LVL_W-1:0]  state_q;
  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             state_q <= '0;
    else if (cnt_load)                      state_q <= cnt_wdata;
    else if (delay_adv && state_q < ORIGIN) state_q <= state_q + LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hold_q <= '0;
    else if (hold_load)                  hold_q <= ~hold_code;
    else if (hold_adv && hold_q != '0)   hold_q <= hold_q - CODE_W'(1);
  end

  assign delay_done = delay_adv && (state_q >= LAST);
  assign hold_done  = hold_adv && (hold_q == '0);
endmodule

// File: rtl/venv_step.sv
module venv_step
  import venv_pkg::*;
(
  input  logic [LVL_W-1:0]  level,
  input  logic [CODE_W-1:0] atk_code,
  input  logic [CODE_W-1:0] dec_code,
  input  logic [CODE_W-1:0] sus_code,
  output logic [LVL_W-1:0]  atk_next,
  output logic              atk_full,
  output logic [LVL_W-1:0]  dec_next,
  output logic              dec_landed,
  output logic [LVL_W-1:0]  rel_next,
  output logic              rel_zero
);
  logic [LVL_W:0]   atk_sum;
  logic [LVL_W-1:0] dstep, target;

  assign atk_sum    = {1'b0, level} + {1'b0, f_attack_step(atk_code)};
  assign atk_full   = atk_sum >= {1'b0, {LVL_W{1'b1}}};
  assign atk_next   = atk_full ? {LVL_W{1'b1}} : atk_sum[LVL_W-1:0];

  assign dstep      = f_decay_step(level, dec_code);
  assign target     = f_sustain_target(sus_code);
  assign dec_landed = {1'b0, level} <= ({1'b0, target} + {1'b0, dstep});
  assign dec_next   = dec_landed ? target : level - dstep;

  assign rel_zero   = level <= dstep;
  assign rel_next   = rel_zero ? '0 : level - dstep;
endmodule

// File: rtl/venv_gen.sv
module venv_gen
  import venv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] env_level,
  output logic [2:0]  env_phase
);
  venv_phase_e       phase_q;
  logic [LVL_W-1:0]  level_q;
  logic [CODE_W-1:0] atk_code, hold_code, sus_code, dec_code;
  logic              frozen, start_evt, release_evt, cnt_load;
  logic              adv, delay_adv, hold_adv, enter_hold;
  logic              delay_done, hold_done;
  logic [LVL_W-1:0]  atk_next, dec_next, rel_next;
  logic              atk_full, dec_landed, rel_zero;

  // A tick counts only when no write happens in the same cycle and the engine runs.
  assign adv        = tick && !frozen && !wr_en;
  assign delay_adv  = adv && (phase_q == PH_DELAY);
  assign hold_adv   = adv && (phase_q == PH_HOLD);
  assign enter_hold = adv && (phase_q == PH_ATTACK) && atk_full;

  venv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .atk_code(atk_code), .hold_code(hold_code), .sus_code(sus_code),
    .dec_code(dec_code), .frozen(frozen), .start_evt(start_evt),
    .release_evt(release_evt), .cnt_load(cnt_load)
  );

  venv_timer u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_wdata(wr_data),
    .delay_adv(delay_adv), .hold_load(enter_hold), .hold_code(hold_code),
    .hold_adv(hold_adv), .delay_done(delay_done), .hold_done(hold_done)
  );

  venv_step u_step (
    .level(level_q), .atk_code(atk_code), .dec_code(dec_code), .sus_code(sus_code),
    .atk_next(atk_next), .atk_full(atk_full), .dec_next(dec_next),
    .dec_landed(dec_landed), .rel_next(rel_next), .rel_zero(rel_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      level_q <= '0;
    end else if (start_evt) begin
      phase_q <= PH_DELAY;
      level_q <= '0;
    end else if (release_evt) begin
      phase_q <= PH_RELEASE;
    end else if (adv) begin
      unique case (phase_q)
        PH_DELAY: if (delay_done) phase_q <= PH_ATTACK;
        PH_ATTACK: begin
          level_q <= atk_next;
          if (atk_full) phase_q <= PH_HOLD;
        end
        PH_HOLD: if (hold_done) phase_q <= PH_DECAY;
        PH_DECAY: begin
          level_q <= dec_next;
          if (dec_landed) phase_q <= PH_SUSTAIN;
        end
        PH_RELEASE: begin
          level_q <= rel_next;
          if (rel_zero) phase_q <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign env_level = level_q;
  assign env_phase = phase_q;
endmodule

// File: rtl/venv_chk.sv
module venv_chk
  import venv_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [15:0] wr_data,
  input logic        frozen,
  input logic [6:0]  atk_code,
  input logic [2:0]  phase,
  input logic [15:0] level
);
  // R2
  start_to_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == SEL_AH && !wr_data[CMD_BIT] |=> phase == PH_DELAY && level == 16'd0);
  // R3
  delay_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DELAY |-> level == 16'd0);
  // R4
  attack_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ATTACK && !wr_en |=> level >= $past(level));
  // R5
  attack_zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ATTACK && atk_code == 7'd0 && !wr_en |=> level == 16'd0);
  // R6
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HOLD |-> level == 16'hFFFF);
  // R8
  sustain_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SUSTAIN && !wr_en |=> phase == PH_SUSTAIN && $stable(level));
  // R9
  release_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_RELEASE && !wr_en |=> level <= $past(level));
  // R10
  frozen_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !wr_en |=> $stable(level) && $stable(phase));
endmodule

bind venv_gen venv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .frozen(frozen), .atk_code(atk_code), .phase(phase_q), .level(level_q)
);

// File: tb/venv_gen_test.sv
module venv_gen_test;
  localparam int P_IDLE = 0, P_DELAY = 1, P_ATTACK = 2, P_HOLD = 3,
                 P_DECAY = 4, P_SUSTAIN = 5, P_RELEASE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] env_level;
  logic [2:0]  env_phase;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  int m_lvl = 0, m_ph = P_IDLE, m_cnt = 0, m_hc = 0;
  int f_atk = 0, f_hold = 0, f_sus = 0, f_dec = 0, f_frz = 0;

  venv_gen uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
                .wr_data(wr_data), .env_level(env_level), .env_phase(env_phase));

  always #4 clk = ~clk;

  function automatic int rise_of(int a);
    if (a == 0) return 0;
    return (a + 1) * (2 ** (a / 16));
  endfunction

  function automatic int fall_of(int l, int d);
    return l / (2 ** (8 - d / 16)) + d % 16 + 1;
  endfunction

  function automatic int floor_of(int s);
    int k;
    if (s == 0) return 0;
    k = 127 - s;
    return (65535 - 4096 * (k % 8)) / (2 ** (k / 8));
  endfunction

  task automatic ref_write(int sel, int d);
    if (sel == 0) m_cnt = d;
    else if (sel == 1) begin
      f_hold = (d / 256) % 128; f_atk = d % 128;
      if (d < 32768) begin m_ph = P_DELAY; m_lvl = 0; end
    end else if (sel == 2) begin
      f_sus = (d / 256) % 128; f_frz = (d / 128) % 2; f_dec = d % 128;
      if (d >= 32768) m_ph = P_RELEASE;
      else begin m_ph = P_DELAY; m_lvl = 0; end
    end
  endtask

  task automatic ref_tick();
    int s;
    if (f_frz != 0) return;
    case (m_ph)
      P_DELAY: begin
        if (m_cnt >= 32767) m_ph = P_ATTACK;
        if (m_cnt < 32768) m_cnt++;
      end
      P_ATTACK: begin
        s = rise_of(f_atk);
        if (m_lvl + s >= 65535) begin m_lvl = 65535; m_ph = P_HOLD; m_hc = 127 - f_hold; end
        else m_lvl += s;
      end
      P_HOLD: if (m_hc == 0) m_ph = P_DECAY; else m_hc--;
      P_DECAY: begin
        s = fall_of(m_lvl, f_dec);
        if (m_lvl - s <= floor_of(f_sus)) begin m_lvl = floor_of(f_sus); m_ph = P_SUSTAIN; end
        else m_lvl -= s;
      end
      P_RELEASE: begin
        s = fall_of(m_lvl, f_dec);
        if (m_lvl <= s) begin m_lvl = 0; m_ph = P_IDLE; end
        else m_lvl -= s;
      end
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    n_chk++;
    if (int'(env_level) != m_lvl || int'(env_phase) != m_ph) begin
      n_bad++;
      $display("FAIL %s: level/phase got %0d/%0d expected %0d/%0d",
               tag, env_level, env_phase, m_lvl, m_ph);
    end
  endtask

  task automatic expect_eq(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One cycle of stimulus, reference update, and comparison.
  task automatic op(bit we, int sel, int d, bit tk, string tag);
    @(negedge clk);
    wr_en = we; wr_sel = 2'(sel); wr_data = 16'(d); tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    if (we) ref_write(sel, d);
    else if (tk) ref_tick();
    compare(tag);
  endtask

  task automatic wr(int sel, int d, string tag);
    op(1'b1, sel, d, 1'b0, tag);
  endtask

  task automatic tk(string tag);
    op(1'b0, 0, 0, 1'b1, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_eq("R1 level", int'(env_level), 0);
    expect_eq("R1 phase", int'(env_phase), P_IDLE);
  endtask

  task automatic t_full_note();
    int cnt;
    wr(0, 32768 - 3, "R3 load");
    wr(1, 32768 + 125 * 256 + 37, "R2 no start");
    expect_eq("R2 fields-only write keeps IDLE", int'(env_phase), P_IDLE);
    wr(2, 119 * 256 + 112, "R2 start from ds");
    expect_eq("R2 phase DELAY", int'(env_phase), P_DELAY);
    tk("R3"); tk("R3");
    expect_eq("R3 still delayed after 2", int'(env_phase), P_DELAY);
    tk("R3");
    expect_eq("R3 attack on 3rd tick", int'(env_phase), P_ATTACK);
    tk("R4");
    expect_eq("R4 first attack step", int'(env_level), 152);
    cnt = 1;
    while (int'(env_phase) == P_ATTACK && cnt < 1000) begin tk("R4"); cnt++; end
    expect_eq("R4 ticks to full", cnt, 432);
    expect_eq("R4 full level", int'(env_level), 65535);
    cnt = 0;
    while (int'(env_phase) == P_HOLD && cnt < 200) begin tk("R6"); cnt++; end
    expect_eq("R6 hold length", cnt, 3);
    cnt = 0;
    while (int'(env_phase) != P_SUSTAIN && cnt < 200) begin tk("R8"); cnt++; end
    expect_eq("R7 sustain 119", int'(env_level), 32767);
    for (int i = 0; i < 4; i++) tk("R8 sustain holds");
    expect_eq("R8 still sustain", int'(env_phase), P_SUSTAIN);
  endtask

  task automatic run_sustain(int sus, int exp);
    int cnt;
    wr(1, 32768 + 127 * 256 + 127, "R2");
    wr(0, 32768, "R3");
    wr(2, sus * 256 + 112, "R2");
    tk("R3 immediate");
    expect_eq("R3 S>=0x8000 first tick", int'(env_phase), P_ATTACK);
    cnt = 0;
    while (int'(env_phase) != P_SUSTAIN && cnt < 300) begin tk("R8"); cnt++; end
    expect_eq("R7 sustain target", int'(env_level), exp);
  endtask

  task automatic t_sustain_levels();
    run_sustain(127, 65535);
    run_sustain(120, 36863);
    run_sustain(1, 1);
    run_sustain(0, 0);
  endtask

  task automatic t_release();
    int cnt;
    run_sustain(119, 32767);
    wr(2, 32768 + 119 * 256 + 0, "R9 release");
    expect_eq("R9 release keeps level", int'(env_level), 32767);
    tk("R9");
    expect_eq("R9 first release step", int'(env_level), 32639);
    cnt = 0;
    while (int'(env_phase) == P_RELEASE && cnt < 5000) begin tk("R9"); cnt++; end
    expect_eq("R9 ends idle", int'(env_phase), P_IDLE);
    expect_eq("R9 ends silent", int'(env_level), 0);
    // release mid-attack
    wr(0, 32768, "R3");
    wr(1, 32768 + 127 * 256 + 37, "R2");
    wr(1, 127 * 256 + 37, "R2 start");
    for (int i = 0; i < 4; i++) tk("R4");
    expect_eq("R4 three steps", int'(env_level), 456);
    wr(2, 32768 + 112, "R9 release from attack");
    cnt = 0;
    while (int'(env_phase) == P_RELEASE && cnt < 100) begin tk("R9"); cnt++; end
    expect_eq("R9 attack release idle", int'(env_phase), P_IDLE);
  endtask

  task automatic t_zero_attack();
    wr(0, 32768, "R3");
    wr(1, 0, "R5 start code0");
    for (int i = 0; i < 20; i++) tk("R5");
    expect_eq("R5 level zero", int'(env_level), 0);
    expect_eq("R5 phase attack", int'(env_phase), P_ATTACK);
  endtask

  task automatic t_freeze();
    int held;
    run_sustain(119, 32767);
    wr(2, 32768 + 128 + 112, "R10 frozen release");
    held = int'(env_level);
    for (int i = 0; i < 6; i++) tk("R10");
    expect_eq("R10 level frozen", int'(env_level), held);
    expect_eq("R10 phase frozen", int'(env_phase), P_RELEASE);
    wr(2, 32768 + 112, "R10 unfreeze");
    tk("R10");
    expect_eq("R10 resumed", int'(env_level), 32767 - fall_of(32767, 112));
    // frozen during a pending delay
    wr(0, 32767, "R3");
    wr(2, 128 + 112, "R10 frozen start");
    for (int i = 0; i < 3; i++) tk("R10");
    expect_eq("R10 delay frozen", int'(env_phase), P_DELAY);
    wr(2, 112, "R10 restart");
    tk("R10");
    expect_eq("R10 delay count kept", int'(env_phase), P_ATTACK);
  endtask

  task automatic t_ignored();
    wr(3, 16'hFFFF, "R11 sel3");
    expect_eq("R11 sel3 phase", int'(env_phase), P_ATTACK);
    wr(0, 32768 - 20, "R3");
    wr(1, 127 * 256 + 127, "R2 start");
    tk("R3");
    op(1'b1, 0, 32768 - 16, 1'b1, "R11 write+tick");
    expect_eq("R11 tick ignored", int'(env_phase), P_DELAY);
    for (int i = 0; i < 15; i++) tk("R3");
    expect_eq("R11 still delay after 15", int'(env_phase), P_DELAY);
    tk("R3");
    expect_eq("R11 attack on 16th", int'(env_phase), P_ATTACK);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_note();
    t_sustain_levels();
    t_release();
    t_zero_attack();
    t_freeze();
    t_ignored();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule